// File: doc/BRIEF.md
# Serial Memory Bus Front End

This block sits between the four serial pins of a memory device (select, clock, data in, pause) and the device core. Four things happen in the block. The pins are sampled with the system clock. Each bit is taken in on a serial clock rising edge, most significant bit first. The completed bytes go to the core as single-cycle strobes. The first byte of a selection is the command, the next three bytes form a 24-bit byte address, and every byte after that is a data byte. A 512K x 8 array uses the low 19 bits of the address: 8 sectors, each of 256 pages, each of 256 bytes.

Bytes going back to the host are written into a one-byte holding register through a load strobe. The serial output picks that byte up on the falling edge that ends the byte in flight, and it changes only after falling edges. The block does nothing after reset until it has seen the select line fall. A pause input stops the shift logic between two clock pulses and releases the output while the device stays selected. Deselecting in the middle of a byte throws the partial byte away.

Top module: `spi_mem_frontend`

## Requirements
- R1: The first complete byte after select goes low is shifted in MSB first on serial clock rising edges and is presented on `rx_byte` with a one-cycle `instr_valid`.
- R2: The next three bytes are assembled most significant byte first into `addr` (the first of them is addr[23:16]), and `addr_valid` pulses once after the third byte.
- R3: Every later byte of the same selection pulses `data_valid` with the byte on `rx_byte`. There is no limit on the count, so runs of 1 to 256 bytes and longer all give one strobe per byte.
- R4: `so_o` changes only in the cycle that follows a detected serial clock falling edge.
- R5: While select is high, `so_oe` is low.
- R6: After reset, no strobe is raised and `so_oe` stays low until a falling edge of the select line has been seen. The synchronised select level starts low, so a line that is held low through reset does not count as a falling edge.
- R7: While paused, clock edges are ignored, `so_oe` is low, and `so_o` holds its value. The bit count and the shift contents are kept exactly, so the byte resumes where it stopped. Pause starts and ends only while the serial clock is low.
- R8: If select rises in the middle of a byte, the partial bits are discarded and the next selection starts again with a command byte.
- R9: A byte written with `tx_load` before the falling edge that ends the current byte is driven on `so_o` MSB first during the next byte, one bit after each falling edge.
- R10: At most one of `instr_valid`, `addr_valid` and `data_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Select pin, active low |
| sck | input | 1 | Serial clock pin, idles low |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause pin, active low |
| tx_load | input | 1 | Strobe that writes `tx_byte` into the outbound holding register |
| tx_byte | input | 8 | Next outbound byte |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data out pad |
| instr_valid | output | 1 | Command byte strobe |
| addr_valid | output | 1 | Address complete strobe |
| data_valid | output | 1 | Data byte strobe |
| rx_byte | output | 8 | Last received command or data byte |
| addr | output | 24 | Assembled byte address |

## Verification
Every one of the 256 command codes is sent in its own selection. A design that shifted LSB first, or that dropped a bit, would report a different code. A run of 256 data bytes after an address shows whether a byte counter wraps or saturates too early and loses or repeats strobes. The bench also covers three edge cases:
- A select that is low through reset, which checks that an already-low line is not taken as an arming edge.
- A selection cut off after five bits, which would leave stale bits or a wrong byte phase in a design that fails to clear on deselect.
- A pause in the middle of a byte while clock pulses keep arriving, which a design that kept shifting would corrupt, both in the received address and in the byte being returned.

// File: rtl/spi_fe_pkg.sv
// Shared definitions for the serial memory front end.
// Assumes: the byte width is a power of two.
package spi_fe_pkg;
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings asynchronous pins into the clk domain through a chain of flops per pin.
// Assumes: STAGES >= 2; RST_VAL gives each pin's level during reset.
module spi_pin_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Shift the raw pin level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], pin_i[g]};
        end
        assign lvl_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_rx_engine.sv
// Receives serial bits, splits them into command, address and data bytes,
// and strobes each completed item for one cycle.
// Assumes: shift_en pulses once per qualified serial rising edge; active low
// clears the byte framing.
module spi_rx_engine
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       shift_en,
    input  logic                       mosi,
    output logic                       bit_zero,
    output logic                       instr_valid,
    output logic                       addr_valid,
    output logic                       data_valid,
    output logic [BYTE_W-1:0]          rx_byte,
    output logic [ADDR_BYTES*BYTE_W-1:0] addr
);
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int ACW    = $clog2(ADDR_BYTES + 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [ACW-1:0]    abyte_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    phase_e            phase;

    assign next_byte = {shreg[BYTE_W-2:0], mosi};
    assign bit_zero  = (bit_cnt == '0);

    // Count bits, move through command/address/data phases, raise strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            abyte_cnt   <= '0;
            shreg       <= '0;
            phase       <= PH_CMD;
            instr_valid <= 1'b0;
            addr_valid  <= 1'b0;
            data_valid  <= 1'b0;
            rx_byte     <= '0;
            addr        <= '0;
        end else begin
            instr_valid <= 1'b0;
            addr_valid  <= 1'b0;
            data_valid  <= 1'b0;
            if (!active) begin
                bit_cnt   <= '0;
                abyte_cnt <= '0;
                phase     <= PH_CMD;
            end else if (shift_en) begin
                shreg <= next_byte;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    bit_cnt <= '0;
                    case (phase)
                        PH_CMD: begin
                            rx_byte     <= next_byte;
                            instr_valid <= 1'b1;
                            phase       <= PH_ADDR;
                        end
                        PH_ADDR: begin
                            addr      <= {addr[ADDR_W-BYTE_W-1:0], next_byte};
                            abyte_cnt <= abyte_cnt + 1'b1;
                            if (abyte_cnt == ACW'(ADDR_BYTES - 1)) begin
                                addr_valid <= 1'b1;
                                phase      <= PH_DATA;
                            end
                        end
                        default: begin
                            rx_byte    <= next_byte;
                            data_valid <= 1'b1;
                        end
                    endcase
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_tx_engine.sv
// Holds the next outbound byte and shifts it out MSB first, one bit per
// qualified serial falling edge; a new byte is taken at each byte boundary.
// Assumes: byte_start is high on the falling edge that ends an inbound byte.
module spi_tx_engine #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              shift_en,
    input  logic              byte_start,
    output logic              so_bit
);
    logic [BYTE_W-1:0] pending;
    logic [BYTE_W-1:0] shreg;

    // Capture the byte offered by the core.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= '0;
        else if (tx_load) pending <= tx_byte;
    end

    // Load or advance the output shifter on falling edges only.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= byte_start ? pending : {shreg[BYTE_W-2:0], 1'b0};
    end

    assign so_bit = shreg[BYTE_W-1];
endmodule

// File: rtl/spi_mem_frontend.sv
// Serial memory bus front end: synchronises pins, qualifies select after
// reset, applies pause, and connects the receive and transmit engines.
// Assumes: clk runs at least eight times the serial clock rate.
module spi_mem_frontend #(
    parameter int BYTE_W      = 8,
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sck,
    input  logic                         mosi,
    input  logic                         hold_n,
    input  logic                         tx_load,
    input  logic [BYTE_W-1:0]            tx_byte,
    output logic                         so_o,
    output logic                         so_oe,
    output logic                         instr_valid,
    output logic                         addr_valid,
    output logic                         data_valid,
    output logic [BYTE_W-1:0]            rx_byte,
    output logic [ADDR_BYTES*BYTE_W-1:0] addr
);
    logic [3:0] lvl;
    logic cs_lvl, sck_lvl, mosi_lvl, hold_lvl;
    logic cs_prev, sck_prev;
    logic cs_fall, sck_rise, sck_fall;
    logic armed, holding, active, bit_zero;

    // Pin order {hold_n, mosi, sck, cs_n}; select resets low so a line held
    // low through reset is not mistaken for a falling edge.
    spi_pin_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({hold_n, mosi, sck, cs_n}), .lvl_o(lvl)
    );
    assign {hold_lvl, mosi_lvl, sck_lvl, cs_lvl} = lvl;

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev  <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end
    assign cs_fall  = cs_prev & ~cs_lvl;
    assign sck_rise = ~sck_prev & sck_lvl;
    assign sck_fall = sck_prev & ~sck_lvl;

    // Arm once the first select falling edge follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (cs_fall) armed <= 1'b1;
    end
    assign active = armed & ~cs_lvl;

    // Pause state changes only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) holding <= 1'b0;
        else if (!sck_lvl)     holding <= ~hold_lvl;
    end

    assign so_oe = active & ~holding;

    spi_rx_engine #(.BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES)) u_rx (
        .clk(clk), .rst_n(rst_n), .active(active),
        .shift_en(sck_rise & active & ~holding), .mosi(mosi_lvl),
        .bit_zero(bit_zero), .instr_valid(instr_valid), .addr_valid(addr_valid),
        .data_valid(data_valid), .rx_byte(rx_byte), .addr(addr)
    );

    spi_tx_engine #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_byte(tx_byte),
        .shift_en(sck_fall & active & ~holding), .byte_start(bit_zero),
        .so_bit(so_o)
    );
endmodule

// File: rtl/spi_mem_frontend_chk.sv
// Property checker for spi_mem_frontend, attached by bind.
// Assumes: signals named as in the top module.
module spi_mem_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_valid,
    input logic addr_valid,
    input logic data_valid,
    input logic so_o,
    input logic so_oe,
    input logic cs_lvl,
    input logic sck_fall,
    input logic holding,
    input logic armed
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_valid, addr_valid, data_valid})); // R10
    AST_SO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (so_o != $past(so_o)) |-> $past(sck_fall)); // R4
    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |-> !so_oe); // R5
    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !(so_oe || instr_valid || addr_valid || data_valid)); // R6
    AST_HOLD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        holding |-> !(so_oe || instr_valid || addr_valid || data_valid)); // R7
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && $past(holding)) |-> $stable(so_o)); // R7
endmodule

bind spi_mem_frontend spi_mem_frontend_chk u_chk (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .addr_valid(addr_valid),
    .data_valid(data_valid), .so_o(so_o), .so_oe(so_oe), .cs_lvl(cs_lvl),
    .sck_fall(sck_fall), .holding(holding), .armed(armed)
);

// File: tb/spi_mem_frontend_bench.sv
module spi_mem_frontend_bench;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic tx_load = 1'b0;
    logic [7:0] tx_byte = '0;
    logic so_o, so_oe, instr_valid, addr_valid, data_valid;
    logic [7:0] rx_byte;
    logic [23:0] addr;

    int n_cmp = 0, n_bad = 0;
    int n_ins = 0, n_adr = 0, n_dat = 0;
    logic [7:0]  ins_log [0:15];
    logic [23:0] adr_log [0:15];
    logic [7:0]  dat_log [0:299];
    bit oe_lost = 1'b0;

    always #2.5 clk = ~clk;

    spi_mem_frontend u_spi_mem_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
        .tx_load(tx_load), .tx_byte(tx_byte), .so_o(so_o), .so_oe(so_oe),
        .instr_valid(instr_valid), .addr_valid(addr_valid), .data_valid(data_valid),
        .rx_byte(rx_byte), .addr(addr)
    );

    // Record every strobe the design raises.
    always @(posedge clk) begin
        if (instr_valid) begin if (n_ins < 16) ins_log[n_ins] <= rx_byte; n_ins <= n_ins + 1; end
        if (addr_valid)  begin if (n_adr < 16) adr_log[n_adr] <= addr;    n_adr <= n_adr + 1; end
        if (data_valid)  begin if (n_dat < 300) dat_log[n_dat] <= rx_byte; n_dat <= n_dat + 1; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_logs();
        @(negedge clk);
        n_ins = 0; n_adr = 0; n_dat = 0; oe_lost = 1'b0;
    endtask

    task automatic bit_io(input logic b, output logic r);
        mosi = b;
        wait_n(HALF);
        r = so_o;
        if (!so_oe) oe_lost = 1'b1;
        sck = 1'b1;
        wait_n(HALF);
        sck = 1'b0;
    endtask

    task automatic byte_io(input logic [7:0] v, input bit do_load, input logic [7:0] lv,
                           output logic [7:0] r);
        wait_n(HALF);
        if (do_load) begin
            tx_byte = lv; tx_load = 1'b1;
            wait_n(1);
            tx_load = 1'b0;
        end
        for (int i = 7; i >= 0; i--) bit_io(v[i], r[i]);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_n(HALF);
    endtask

    task automatic desel();
        wait_n(HALF);
        cs_n = 1'b1;
        wait_n(10);
    endtask

    logic [7:0] rd;
    logic rb;
    bit done = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        // Reset state (R6): select low through reset, nothing driven.
        chk(!so_oe && !instr_valid && !addr_valid && !data_valid, "R6 reset state", {31'd0, so_oe}, 0);

        // R6: select never fell, a full byte must be ignored.
        clear_logs();
        byte_io(8'h9F, 0, 0, rd);
        wait_n(10);
        chk(n_ins == 0, "R6 unarmed byte ignored", n_ins, 0);
        chk(oe_lost, "R6 output not driven while unarmed", {31'd0, oe_lost}, 1);
        cs_n = 1'b1;
        wait_n(10);
        chk(!so_oe, "R5 deselected output off", {31'd0, so_oe}, 0);

        // R1: every command code, each in its own selection.
        for (int c = 0; c < 256; c++) begin
            clear_logs();
            sel();
            byte_io(8'(c), 0, 0, rd);
            desel();
            chk(n_ins == 1 && ins_log[0] == 8'(c) && n_adr == 0 && n_dat == 0,
                "R1 command byte", {24'd0, ins_log[0]}, c);
        end

        // R2, R3, R9: address, 256 data bytes, and read-back sweep.
        clear_logs();
        tx_byte = 8'hA5; tx_load = 1'b1; wait_n(1); tx_load = 1'b0;
        sel();
        byte_io(8'h03, 0, 0, rd);
        byte_io(8'h07, 1, 8'h11, rd);
        chk(rd == 8'hA5, "R9 first read byte", rd, 8'hA5);
        byte_io(8'hC3, 1, 8'h22, rd);
        chk(rd == 8'h11, "R9 second read byte", rd, 8'h11);
        byte_io(8'h5E, 1, 8'h33, rd);
        chk(rd == 8'h22, "R9 third read byte", rd, 8'h22);
        chk(!oe_lost, "R5 output driven while selected", {31'd0, oe_lost}, 0);
        for (int k = 0; k < 256; k++) begin
            byte_io(8'((k * 7 + 3) & 255), 1, 8'((k * 13 + 1) & 255), rd);
            chk(rd == (k == 0 ? 8'h33 : 8'(((k - 1) * 13 + 1) & 255)), "R9 read sweep",
                rd, (k == 0 ? 8'h33 : 8'(((k - 1) * 13 + 1) & 255)));
        end
        desel();
        chk(!so_oe, "R5 output released at deselect", {31'd0, so_oe}, 0);
        chk(n_adr == 1 && adr_log[0] == 24'h07C35E, "R2 address assembly", adr_log[0], 24'h07C35E);
        chk(n_dat == 256, "R3 data strobe count", n_dat, 256);
        begin
            int bad = 0;
            for (int k = 0; k < 256; k++) if (dat_log[k] != 8'((k * 7 + 3) & 255)) bad++;
            chk(bad == 0, "R3 data byte values", bad, 0);
        end

        // R3: a single data byte.
        clear_logs();
        sel();
        byte_io(8'h02, 0, 0, rd);
        byte_io(8'h00, 0, 0, rd); byte_io(8'h00, 0, 0, rd); byte_io(8'hFF, 0, 0, rd);
        byte_io(8'h81, 0, 0, rd);
        desel();
        chk(n_dat == 1 && dat_log[0] == 8'h81, "R3 single data byte", dat_log[0], 8'h81);
        chk(n_adr == 1 && adr_log[0] == 24'h0000FF, "R2 low address", adr_log[0], 24'h0000FF);

        // R8: select rises after five bits, next selection starts fresh.
        clear_logs();
        sel();
        for (int i = 0; i < 5; i++) bit_io(1'b1, rb);
        desel();
        sel();
        byte_io(8'h0B, 0, 0, rd);
        byte_io(8'h01, 0, 0, rd); byte_io(8'h02, 0, 0, rd); byte_io(8'h03, 0, 0, rd);
        desel();
        chk(n_ins == 1 && ins_log[0] == 8'h0B, "R8 partial byte discarded", ins_log[0], 8'h0B);
        chk(n_adr == 1 && adr_log[0] == 24'h010203, "R8 address after abort", adr_log[0], 24'h010203);

        // R7: pause mid-byte with clock pulses arriving; bits and output kept.
        clear_logs();
        tx_byte = 8'h5A; tx_load = 1'b1; wait_n(1); tx_load = 1'b0;
        sel();
        byte_io(8'h03, 0, 0, rd);
        wait_n(HALF);
        for (int i = 7; i >= 5; i--) begin bit_io(((8'hB6 >> i) & 1) != 0, rb); rd[i] = rb; end
        hold_n = 1'b0;
        wait_n(HALF);
        chk(!so_oe, "R7 output released in pause", {31'd0, so_oe}, 0);
        for (int i = 0; i < 4; i++) begin
            mosi = i[0]; wait_n(HALF); sck = 1'b1; wait_n(HALF); sck = 1'b0;
        end
        chk(n_ins == 1 && n_adr == 0, "R7 no strobe during pause", n_adr, 0);
        wait_n(HALF);
        hold_n = 1'b1;
        wait_n(HALF);
        for (int i = 4; i >= 0; i--) begin bit_io(((8'hB6 >> i) & 1) != 0, rb); rd[i] = rb; end
        chk(rd == 8'h5A, "R7 read byte intact across pause", rd, 8'h5A);
        byte_io(8'h44, 0, 0, rd); byte_io(8'h55, 0, 0, rd);
        desel();
        chk(n_adr == 1 && adr_log[0] == 24'hB64455, "R7 address intact across pause", adr_log[0], 24'hB64455);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule